// File: doc/BRIEF.md
# Reversible Peres-Cascade Weight Counter

This block counts the ones on `NUM_IN` input lines and presents the count in binary. It uses no adders. It is a purely combinational network made only of three-line reversible gates. Each gate maps (a, b, c) to (a, a xor b, c xor (a and b)) and is placed as an explicit primitive instance. Gates that start a carry get a constant-zero ancilla on their third line. Line r of the result is a totally symmetric function of the inputs: it is true exactly when bit r of the input Hamming weight is set.

The network is laid out as an array of rows and levels. Input 0 seeds the first row. Each further input adds one level, in which a carry ripples down the rows. A new row starts whenever the number of inputs absorbed so far reaches a power of two. The unused first output of every gate is a garbage line, and all of them are exported on one vector. This lets the reversibility bookkeeping be checked from outside: there is one garbage bit per gate. Each garbage bit is itself a symmetric function of the inputs that came before its level.

Top module: `sym_weight_cascade`

## Requirements
- R1: The weight output has $clog2(NUM_IN+1) lines, and line r equals bit r of the number of ones on `x`, for every input pattern.
- R2: With all inputs at zero, every weight line and every garbage line is zero.
- R3: With all inputs at one, the weight output equals NUM_IN.
- R4: The weight output depends only on how many inputs are high. It is 1 for any single high input, and any rotation of the input pattern yields the same output.
- R5: The garbage vector is NUM_IN*c - NUM_IN - 2^c + f + 2 bits wide, where c = ceil(log2 NUM_IN) and f = floor(log2 NUM_IN). This is also the number of gates.
- R6: Garbage bits are ordered by level, and within a level by row (row 0 first). Level m (m = 1..NUM_IN-1) absorbs input x[m]. Its rows r are those with 2^r <= m, minus the topmost such row when m+1 is not a power of two. The garbage bit of level m, row r, equals bit r of the number of ones on x[m-1:0]. In particular, garbage bit 0 equals x[0].
- R7: The gate primitive gives p = a, q = a xor b, r = c xor (a and b), and it maps the 8 input triples onto 8 distinct output triples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | NUM_IN | Input lines whose ones are counted |
| weight | output | $clog2(NUM_IN+1) | Binary Hamming weight; line r is the symmetric function for bit r |
| garb | output | GW (see R5) | Garbage lines, one per gate, ordered per R6 |

## Verification
Whenever any input changes, the checker compares the weight lines against a population count of the inputs. It also checks that the all-zero and all-one patterns give the extreme results and that the first garbage line mirrors input 0. Some properties are reached only through the bench's scenarios: the full garbage ordering level by level, the width formula, rotation invariance and the primitive's bijectivity. The bench applies the exhaustive input sweep and the random patterns, and it drives the lone primitive through all eight triples.

// File: rtl/rev_peres3.sv
module rev_peres3 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ^ b;
  assign r = c ^ (a & b);
endmodule

// File: rtl/sym_weight_cascade.sv
module sym_weight_cascade #(
  parameter  int NUM_IN = 16,
  localparam int ROWS   = $clog2(NUM_IN + 1),
  localparam int CL     = $clog2(NUM_IN),
  localparam int FL     = $clog2(NUM_IN + 1) - 1,
  localparam int GW     = NUM_IN * CL - NUM_IN - (1 << CL) + FL + 2
) (
  input  logic [NUM_IN-1:0] x,
  output logic [ROWS-1:0]   weight,
  output logic [GW-1:0]     garb
);

  function automatic int rows_at(int m);
    return $clog2(m + 1);
  endfunction

  function automatic int gates_at(int m);
    return (((m + 1) & m) == 0) ? rows_at(m) : rows_at(m) - 1;
  endfunction

  function automatic int base_at(int m);
    int s = 0;
    for (int i = 1; i < m; i++) s += gates_at(i);
    return s;
  endfunction

  logic [ROWS-1:0] st [NUM_IN];

  assign st[0] = {{(ROWS-1){1'b0}}, x[0]};

  for (genvar m = 1; m < NUM_IN; m++) begin : g_lvl
    localparam int KM     = rows_at(m);
    localparam bit NEWROW = (((m + 1) & m) == 0);
    localparam int NG     = NEWROW ? KM : KM - 1;
    localparam int OFF    = base_at(m);

    logic [NG:0] cy;
    assign cy[0] = x[m];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      if (r < NG) begin : g_gate
        logic c_in;
        if (!NEWROW && r == NG - 1) begin : g_top
          assign c_in = st[m-1][r+1];
        end else begin : g_anc
          assign c_in = 1'b0;
        end
        rev_peres3 u_pg (
          .a(st[m-1][r]),
          .b(cy[r]),
          .c(c_in),
          .p(garb[OFF+r]),
          .q(st[m][r]),
          .r(cy[r+1])
        );
      end else if (r == NG) begin : g_take
        assign st[m][r] = cy[r];
      end else begin : g_pass
        assign st[m][r] = st[m-1][r];
      end
    end
  end

  assign weight = st[NUM_IN-1];

endmodule

// File: rtl/sym_weight_cascade_chk.sv
module sym_weight_cascade_chk #(
  parameter  int NUM_IN = 16,
  localparam int ROWS   = $clog2(NUM_IN + 1),
  localparam int CL     = $clog2(NUM_IN),
  localparam int FL     = $clog2(NUM_IN + 1) - 1,
  localparam int GW     = NUM_IN * CL - NUM_IN - (1 << CL) + FL + 2
) (
  input logic [NUM_IN-1:0] x,
  input logic [ROWS-1:0]   weight,
  input logic [GW-1:0]     garb
);
  always_comb begin
    a_r1_weight_lines: assert (weight == ROWS'($countones(x)));
    a_r2_zero_quiet:   assert (x != '0 || (weight == '0 && garb == '0));
    a_r3_all_ones:     assert (x != '1 || weight == ROWS'(NUM_IN));
    a_r6_first_garb:   assert (garb[0] == x[0]);
  end
endmodule

bind sym_weight_cascade sym_weight_cascade_chk #(.NUM_IN(NUM_IN)) u_chk (
  .x(x),
  .weight(weight),
  .garb(garb)
);

// File: tb/sym_weight_cascade_test.sv
module sym_weight_cascade_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN     = 16;
  localparam int ROWS       = $clog2(NUM_IN + 1);
  localparam int CL         = $clog2(NUM_IN);
  localparam int FL         = $clog2(NUM_IN + 1) - 1;
  localparam int GW_EXP     = NUM_IN * CL - NUM_IN - (1 << CL) + FL + 2;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_IN-1:0] x = '0;
  logic [ROWS-1:0]   weight;
  logic [GW_EXP-1:0] garb;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic pa, pb, pc, pp, pq, pr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_weight_cascade #(.NUM_IN(NUM_IN)) uut (.x(x), .weight(weight), .garb(garb));
  rev_peres3 u_prim (.a(pa), .b(pb), .c(pc), .p(pp), .q(pq), .r(pr));

  function automatic int ones_below(logic [NUM_IN-1:0] v, int m);
    int s = 0;
    for (int i = 0; i < m; i++) s += int'(v[i]);
    return s;
  endfunction

  function automatic logic [63:0] exp_garb(logic [NUM_IN-1:0] v);
    logic [63:0] g = '0;
    int idx = 0;
    for (int m = 1; m < NUM_IN; m++) begin
      int cnt = ones_below(v, m);
      int nrows = 0;
      int ng;
      while ((1 << nrows) <= m) nrows++;
      ng = (((m + 1) & m) == 0) ? nrows : nrows - 1;
      for (int r = 0; r < ng; r++) begin
        g[idx] = cnt[r];
        idx++;
      end
    end
    return g;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [NUM_IN-1:0] v);
    @(negedge clk);
    x = v;
    #1;
  endtask

  task automatic full_check(logic [NUM_IN-1:0] v);
    logic [63:0] eg;
    apply(v);
    eg = exp_garb(v);
    check(weight == ROWS'($countones(v)), "R1 weight lines", 64'(weight), 64'($countones(v)));
    check(garb == eg[GW_EXP-1:0], "R6 garbage order", 64'(garb), 64'(eg[GW_EXP-1:0]));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NUM_IN-1:0] v;
    logic [ROWS-1:0]   w0;
    void'($urandom(32'd20240917));

    repeat (3) @(posedge clk);
    #1;
    check(weight == '0 && garb == '0, "R2 reset state zero", 64'(weight), 64'd0);
    rst_n = 1'b1;

    check($bits(uut.garb) == GW_EXP, "R5 garbage width", 64'($bits(uut.garb)), 64'(GW_EXP));

    apply('1);
    check(weight == ROWS'(NUM_IN), "R3 all ones", 64'(weight), 64'(NUM_IN));

    for (int i = 0; i < NUM_IN; i++) begin
      apply(NUM_IN'(1) << i);
      check(weight == ROWS'(1), "R4 single one", 64'(weight), 64'd1);
    end

    for (int k = 1; k <= NUM_IN; k++) begin
      v = (k == NUM_IN) ? '1 : ((NUM_IN'(1) << k) - 1);
      apply(v);
      check(weight == ROWS'(k), "R1 low run", 64'(weight), 64'(k));
    end

    for (int t = 0; t < 200; t++) begin
      v = NUM_IN'($urandom());
      apply(v);
      w0 = weight;
      for (int s = 1; s < 4; s++) begin
        apply((v << s) | (v >> (NUM_IN - s)));
        check(weight == w0, "R4 rotation invariance", 64'(weight), 64'(w0));
      end
    end

    for (int t = 0; t < 300; t++) full_check(NUM_IN'($urandom()));

    for (int t = 0; t < (1 << NUM_IN); t++) full_check(NUM_IN'(t));

    apply('0);
    check(weight == '0 && garb == '0, "R2 zero input", 64'(garb), 64'd0);

    begin
      logic [7:0] seen = '0;
      for (int t = 0; t < 8; t++) begin
        logic [2:0] o;
        logic [2:0] e;
        pa = t[2]; pb = t[1]; pc = t[0];
        #1;
        o = {pp, pq, pr};
        e = {t[2], t[2] ^ t[1], t[0] ^ (t[2] & t[1])};
        check(o == e, "R7 primitive map", 64'(o), 64'(e));
        seen[o] = 1'b1;
      end
      check(seen == 8'hFF, "R7 primitive bijective", 64'(seen), 64'hFF);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule